// File: doc/BRIEF.md
# Per-Thread Interrupt Presentation Register Interface

This block is the memory-mapped front end that one processor thread uses to talk to its interrupt presentation logic. It decodes byte and word accesses inside a 4 KB page and keeps the presentation state for that thread:

- the current processor priority;
- the inter-processor request priority;
- the single presented interrupt, made of a 24-bit source number and its priority;
- three free 32-bit scratch link registers.

An upstream source controller offers external interrupts one pulse at a time. The block decides whether each offer outranks what the thread is doing, and raises an interrupt line to the processor.

Software selects the operation through the access size as well as the address. At the interrupt register, a one-byte read is a harmless peek at the current priority, while a four-byte read accepts the presented interrupt and raises the thread priority to it. A one-byte write only changes the priority, while a four-byte write ends the interrupt and restores a priority taken from the top byte of the data. Priorities run from 0x00, the most favoured, to 0xFF, the least favoured.

Read data and the error flag are combinational in the access cycle. Every state change, including the side effect of a read, takes place at the clock edge that ends the access.

Top module: `irq_present_port`

## Requirements
- R1: After reset the current priority is 0x00, the inter-processor request priority is 0xFF, no interrupt is presented (source 0), all link registers read 0, and `irq_o` is low.
- R2: `bus_size` gives the access width in bytes, and only 1 and 4 are legal. A one-byte access is usable only with `bus_addr[1:0]`=0. Its read data is returned in `bus_rdata[7:0]` with the upper bits zero, and its write data is taken from `bus_wdata[7:0]`. Any read that is unmapped or wrongly sized returns 0xFFFFFFFF and raises `bus_err` in that cycle.
- R3: A four-byte read at offset 0x000 returns {priority[31:24], source[23:0]} and changes nothing. A one-byte read at offset 0x000 or 0x004 returns the current priority.
- R4: A four-byte read at offset 0x004 returns {priority, source}. After the edge, the priority equals the presented interrupt's priority, the source reads 0 and `irq_o` is low. With nothing presented, it returns {priority, 0} and changes nothing.
- R5: A one-byte write at offset 0x004 loads the current priority. A presented interrupt whose priority is not numerically below the new value is discarded.
- R6: A four-byte write at offset 0x004 ends the interrupt. The priority is loaded from `bus_wdata[31:24]`, and the same discard rule as R5 applies.
- R7: The inter-processor request priority is read and written only by a one-byte access at offset 0x00C.
- R8: Three link registers at offsets 0x010, 0x014 and 0x018 are read and written only by four-byte accesses, and keep what was written.
- R9: An erroneous write changes no state and raises `bus_err`. Erroneous writes include a wrong size, an unmapped offset, a write to offset 0x000, and `bus_rd` with `bus_wr` both high.
- R10: A one-cycle `ext_req` with nonzero `ext_src` is presented only when `ext_prio` is numerically below the current priority and below the priority of any interrupt already presented. Otherwise it is dropped, so on a tie the interrupt already presented stays.
- R11: When the inter-processor request priority is numerically below both the current priority and any presented interrupt's priority, the block presents source 2 with that priority.
- R12: `irq_o` is high exactly while a nonzero source is presented. A presented interrupt always has a priority numerically below the current priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the page |
| bus_size | input | 3 | Access width in bytes (1 or 4 legal) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data, big-endian word; bytes in [7:0] |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Access is illegal; no state change |
| ext_req | input | 1 | One-cycle offer of an external interrupt |
| ext_src | input | 24 | Source number of the offer (0 ignored) |
| ext_prio | input | 8 | Priority of the offer |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A table of accesses covers every offset under both legal sizes, an illegal size, and misaligned and unmapped addresses. It separates the size-selected operations from the error path, and it proves that rejected writes leave the links, the request priority and the current priority untouched.

Directed sequences then offer external interrupts that are better than, equal to and worse than both the current priority and the presented one. This separates replacement, tie retention and rejection.

Accept is exercised with an interrupt presented and with nothing presented. Priority and end-of-interrupt writes both land above and below a presented interrupt, and the inter-processor request priority is moved past, equal to and beyond an external interrupt. Together these distinguish discard, preemption and regeneration after end-of-interrupt.

// File: rtl/irq_present_pkg.sv
// Package: shared types and fixed register offsets for the
// per-thread interrupt presentation register interface.
// Assumes a 4 KB page decoded on 32-bit word boundaries.
package irq_present_pkg;

    // Operation selected by one bus access (address + size + direction)
    typedef enum logic [3:0] {
        OP_NONE,
        OP_ERR,
        OP_POLL_WORD,
        OP_POLL_BYTE,
        OP_ACCEPT,
        OP_SET_PRIO,
        OP_EOI,
        OP_RD_REQ,
        OP_WR_REQ,
        OP_RD_LINK,
        OP_WR_LINK
    } op_e;

    // Legal access widths in bytes
    localparam int unsigned SIZE_BYTE = 1;
    localparam int unsigned SIZE_WORD = 4;

    // Word indices (byte offset / 4); the order matters to software
    localparam int unsigned WIDX_PEEK  = 0;
    localparam int unsigned WIDX_INTR  = 1;
    localparam int unsigned WIDX_REQ   = 3;
    localparam int unsigned WIDX_LINK0 = 4;

endpackage

// File: rtl/irq_present_decode.sv
// Module: irq_present_decode
// Turns one bus access into a single operation code and, for link
// accesses, the link index. Purely combinational.
// Assumes at most one of rd/wr per access; both together is an error.
module irq_present_decode
    import irq_present_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned SIZE_W  = 3,
    parameter int unsigned N_LINKS = 3,
    parameter int unsigned SEL_W   = 2
) (
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output op_e               op,
    output logic [SEL_W-1:0]  link_sel
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    localparam logic [IDX_W-1:0] I_PEEK  = IDX_W'(WIDX_PEEK);
    localparam logic [IDX_W-1:0] I_INTR  = IDX_W'(WIDX_INTR);
    localparam logic [IDX_W-1:0] I_REQ   = IDX_W'(WIDX_REQ);
    localparam logic [IDX_W-1:0] I_LINK0 = IDX_W'(WIDX_LINK0);
    localparam logic [IDX_W-1:0] I_NLINK = IDX_W'(N_LINKS);

    logic [IDX_W-1:0] word_idx;
    logic [IDX_W-1:0] link_off;
    logic             is_byte0;
    logic             is_word;
    logic             in_links;

    // Classify the access width and alignment
    always_comb begin
        word_idx = addr[ADDR_W-1:2];
        is_byte0 = (size == SIZE_W'(SIZE_BYTE)) && (addr[1:0] == 2'b00);
        is_word  = (size == SIZE_W'(SIZE_WORD));
        link_off = word_idx - I_LINK0;
        in_links = (link_off < I_NLINK);
        link_sel = in_links ? link_off[SEL_W-1:0] : '0;
    end

    // Map address, size and direction to one operation
    always_comb begin
        op = OP_ERR;
        if (!rd && !wr) begin
            op = OP_NONE;
        end else if (rd && wr) begin
            op = OP_ERR;
        end else if (word_idx == I_PEEK) begin
            if (rd && is_word)       op = OP_POLL_WORD;
            else if (rd && is_byte0) op = OP_POLL_BYTE;
        end else if (word_idx == I_INTR) begin
            if (rd && is_byte0)      op = OP_POLL_BYTE;
            else if (rd && is_word)  op = OP_ACCEPT;
            else if (wr && is_byte0) op = OP_SET_PRIO;
            else if (wr && is_word)  op = OP_EOI;
        end else if (word_idx == I_REQ) begin
            if (is_byte0)            op = rd ? OP_RD_REQ : OP_WR_REQ;
        end else if (in_links && is_word) begin
            op = rd ? OP_RD_LINK : OP_WR_LINK;
        end
    end

endmodule

// File: rtl/irq_present_links.sv
// Module: irq_present_links
// A bank of N_LINKS word-wide scratch registers with one write port
// and one selected read port. The selector is assumed in range.
module irq_present_links #(
    parameter int unsigned N_LINKS = 3,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [N_LINKS-1:0][DATA_W-1:0] bank;

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        logic [DATA_W-1:0] r_q;

        // Hold one link word; load it when selected
        always_ff @(posedge clk) begin
            if (!rst_n)                                r_q <= '0;
            else if (wr_en && (sel == SEL_W'(g)))      r_q <= wdata;
        end

        assign bank[g] = r_q;
    end

    // Return the selected link word
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_LINKS; i++) begin
            if (sel == SEL_W'(i)) rdata = bank[i];
        end
    end

endmodule

// File: rtl/irq_present_core.sv
// Module: irq_present_core
// Holds the current priority, the inter-processor request priority and
// the single presented interrupt (source + priority). It applies, in one
// cycle and in this order: the bus operation, the discard of a presented
// interrupt no longer better than the priority, an external offer, and
// the inter-processor request. Lower number = more favoured.
// Assumes ext_req is a one-cycle offer; a displaced source is dropped.
module irq_present_core
    import irq_present_pkg::*;
#(
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned SRC_W   = 24,
    parameter int unsigned IPI_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [PRIO_W-1:0] wdata_hi,
    input  logic [PRIO_W-1:0] wdata_lo,
    input  logic              ext_req,
    input  logic [SRC_W-1:0]  ext_src,
    input  logic [PRIO_W-1:0] ext_prio,
    output logic [PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0] req_prio,
    output logic [SRC_W-1:0]  src,
    output logic              irq_o
);

    localparam logic [PRIO_W-1:0] LEAST    = '1;
    localparam logic [SRC_W-1:0]  IPI_CODE = SRC_W'(IPI_SRC);

    logic [PRIO_W-1:0] prio_q, prio_n;
    logic [PRIO_W-1:0] req_q, req_n;
    logic [SRC_W-1:0]  src_q, src_n;
    logic [PRIO_W-1:0] pend_q, pend_n;

    // Compute the next presentation state from the operation and offers
    always_comb begin
        prio_n = prio_q;
        req_n  = req_q;
        src_n  = src_q;
        pend_n = pend_q;

        case (op)
            OP_ACCEPT: begin
                if (src_q != '0) prio_n = pend_q;
                src_n  = '0;
                pend_n = LEAST;
            end
            OP_SET_PRIO: prio_n = wdata_lo;
            OP_EOI:      prio_n = wdata_hi;
            OP_WR_REQ:   req_n  = wdata_lo;
            default: ;
        endcase

        if ((src_n != '0) && !(pend_n < prio_n)) begin
            src_n  = '0;
            pend_n = LEAST;
        end

        if (ext_req && (ext_src != '0) && (ext_prio < prio_n) &&
            ((src_n == '0) || (ext_prio < pend_n))) begin
            src_n  = ext_src;
            pend_n = ext_prio;
        end

        if ((req_n < prio_n) && ((src_n == '0) || (req_n < pend_n))) begin
            src_n  = IPI_CODE;
            pend_n = req_n;
        end
    end

    // Register the presentation state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            req_q  <= LEAST;
            src_q  <= '0;
            pend_q <= LEAST;
        end else begin
            prio_q <= prio_n;
            req_q  <= req_n;
            src_q  <= src_n;
            pend_q <= pend_n;
        end
    end

    // Drive the outputs from the held state
    always_comb begin
        prio     = prio_q;
        req_prio = req_q;
        src      = src_q;
        irq_o    = (src_q != '0) && (pend_q < prio_q);
    end

    AST_PEND_BEATS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q != '0) |-> (pend_q < prio_q)); // R12

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACCEPT && !ext_req) |=> (src_q == '0)); // R4

    AST_EOI_LOADS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EOI) |=> (prio_q == $past(wdata_hi))); // R6

    AST_REQ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_REQ) |=> (req_q == $past(wdata_lo))); // R7

endmodule

// File: rtl/irq_present_port.sv
// Module: irq_present_port (top)
// Per-thread register page of the interrupt presentation logic. Decodes
// the access, steers it to the presentation core or the link bank, and
// builds combinational read data and the error flag.
// Assumes each bus strobe lasts one cycle per access.
module irq_present_port
    import irq_present_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned SIZE_W  = 3,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned SRC_W   = 24,
    parameter int unsigned N_LINKS = 3,
    parameter int unsigned IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [SIZE_W-1:0]         bus_size,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [PRIO_W+SRC_W-1:0]   bus_wdata,
    output logic [PRIO_W+SRC_W-1:0]   bus_rdata,
    output logic                      bus_err,
    input  logic                      ext_req,
    input  logic [SRC_W-1:0]          ext_src,
    input  logic [PRIO_W-1:0]         ext_prio,
    output logic                      irq_o
);

    localparam int unsigned DATA_W = PRIO_W + SRC_W;
    localparam int unsigned SEL_W  = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;

    op_e               op;
    logic [SEL_W-1:0]  link_sel;
    logic [DATA_W-1:0] link_rdata;
    logic [PRIO_W-1:0] prio;
    logic [PRIO_W-1:0] req_prio;
    logic [SRC_W-1:0]  src;

    irq_present_decode #(
        .ADDR_W  (ADDR_W),
        .SIZE_W  (SIZE_W),
        .N_LINKS (N_LINKS),
        .SEL_W   (SEL_W)
    ) u_decode (
        .rd       (bus_rd),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .size     (bus_size),
        .op       (op),
        .link_sel (link_sel)
    );

    irq_present_core #(
        .PRIO_W  (PRIO_W),
        .SRC_W   (SRC_W),
        .IPI_SRC (IPI_SRC)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .wdata_hi (bus_wdata[DATA_W-1 -: PRIO_W]),
        .wdata_lo (bus_wdata[PRIO_W-1:0]),
        .ext_req  (ext_req),
        .ext_src  (ext_src),
        .ext_prio (ext_prio),
        .prio     (prio),
        .req_prio (req_prio),
        .src      (src),
        .irq_o    (irq_o)
    );

    irq_present_links #(
        .N_LINKS (N_LINKS),
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W)
    ) u_links (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (op == OP_WR_LINK),
        .sel   (link_sel),
        .wdata (bus_wdata),
        .rdata (link_rdata)
    );

    // Select the read data and flag illegal accesses
    always_comb begin
        bus_err = (op == OP_ERR);
        case (op)
            OP_POLL_WORD,
            OP_ACCEPT:    bus_rdata = {prio, src};
            OP_POLL_BYTE: bus_rdata = DATA_W'(prio);
            OP_RD_REQ:    bus_rdata = DATA_W'(req_prio);
            OP_RD_LINK:   bus_rdata = link_rdata;
            OP_ERR:       bus_rdata = '1;
            default:      bus_rdata = '0;
        endcase
    end

    AST_ERR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_err) |-> (bus_rdata == '1)); // R2

    AST_ERR_WRITE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_err) |=> ($stable(prio) && $stable(req_prio))); // R9

endmodule

// File: tb/tb_irq_present_port.sv
`timescale 1ns/100ps
module tb_irq_present_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ext_req = 1'b0;
    logic [23:0] ext_src = '0;
    logic [7:0]  ext_prio = '0;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    irq_present_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .ext_req(ext_req),
        .ext_src(ext_src), .ext_prio(ext_prio), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [11:0] addr;
        logic [2:0]  sz;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        eerr;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 12'h010, 3'd4, 32'h0,        32'h0,        1'b0, 4'd1}, // R1 link reset
        '{1'b0, 1'b1, 12'h010, 3'd4, 32'hDEADBEEF, 32'h0,        1'b0, 4'd8}, // R8
        '{1'b1, 1'b0, 12'h010, 3'd4, 32'h0,        32'hDEADBEEF, 1'b0, 4'd8},
        '{1'b0, 1'b1, 12'h014, 3'd4, 32'h12345678, 32'h0,        1'b0, 4'd8},
        '{1'b0, 1'b1, 12'h018, 3'd4, 32'hA5A50F0F, 32'h0,        1'b0, 4'd8},
        '{1'b1, 1'b0, 12'h014, 3'd4, 32'h0,        32'h12345678, 1'b0, 4'd8},
        '{1'b1, 1'b0, 12'h018, 3'd4, 32'h0,        32'hA5A50F0F, 1'b0, 4'd8},
        '{1'b0, 1'b1, 12'h010, 3'd1, 32'h11,       32'hFFFFFFFF, 1'b1, 4'd9}, // R9
        '{1'b1, 1'b0, 12'h010, 3'd4, 32'h0,        32'hDEADBEEF, 1'b0, 4'd9},
        '{1'b1, 1'b0, 12'h010, 3'd1, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2}, // R2
        '{1'b1, 1'b0, 12'h00C, 3'd1, 32'h0,        32'h000000FF, 1'b0, 4'd1},
        '{1'b1, 1'b0, 12'h00C, 3'd4, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2},
        '{1'b0, 1'b1, 12'h00C, 3'd4, 32'h10,       32'hFFFFFFFF, 1'b1, 4'd9},
        '{1'b1, 1'b0, 12'h00C, 3'd1, 32'h0,        32'h000000FF, 1'b0, 4'd9},
        '{1'b1, 1'b0, 12'h00D, 3'd1, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2},
        '{1'b1, 1'b0, 12'h000, 3'd4, 32'h0,        32'h00000000, 1'b0, 4'd3}, // R3
        '{1'b1, 1'b0, 12'h000, 3'd2, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2},
        '{1'b1, 1'b0, 12'h01C, 3'd4, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2},
        '{1'b1, 1'b0, 12'h008, 3'd4, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2},
        '{1'b0, 1'b1, 12'h000, 3'd4, 32'hFF000000, 32'hFFFFFFFF, 1'b1, 4'd9},
        '{1'b1, 1'b0, 12'h004, 3'd1, 32'h0,        32'h00000000, 1'b0, 4'd3},
        '{1'b1, 1'b0, 12'h100, 3'd4, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2},
        '{1'b1, 1'b1, 12'h010, 3'd4, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd9},
        '{1'b1, 1'b0, 12'h010, 3'd4, 32'h0,        32'hDEADBEEF, 1'b0, 4'd9},
        '{1'b0, 1'b1, 12'h00C, 3'd1, 32'h42,       32'h0,        1'b0, 4'd7}, // R7
        '{1'b1, 1'b0, 12'h00C, 3'd1, 32'h0,        32'h00000042, 1'b0, 4'd7},
        '{1'b0, 1'b1, 12'h00C, 3'd1, 32'hFF,       32'h0,        1'b0, 4'd7}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access: drive, sample mid-cycle, end at the next edge
    task automatic acc(input logic rd, input logic wr, input logic [11:0] a,
                       input logic [2:0] sz, input logic [31:0] wd,
                       output logic [31:0] rv, output logic ev);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        #1;
        rv = bus_rdata;
        ev = bus_err;
        @(posedge clk);
        #1;
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic offer(input logic [23:0] s, input logic [7:0] p);
        ext_req = 1'b1; ext_src = s; ext_prio = p;
        @(posedge clk);
        #1;
        ext_req = 1'b0;
    endtask

    task automatic poll(output logic [31:0] v);
        logic e;
        acc(1'b1, 1'b0, 12'h000, 3'd4, 32'h0, v, e);
    endtask

    task automatic wr_op(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] wd);
        logic [31:0] v;
        logic e;
        acc(1'b0, 1'b1, a, sz, wd, v, e);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rv;
        logic        ev;

        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            acc(VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].sz, VECS[i].wd, rv, ev);
            chk($sformatf("R%0d err vec %0d", VECS[i].req, i), {31'b0, ev}, {31'b0, VECS[i].eerr});
            if (VECS[i].rd || VECS[i].eerr)
                chk($sformatf("R%0d data vec %0d", VECS[i].req, i), rv, VECS[i].exp);
        end

        // R10 / R12: external offer presented
        wr_op(12'h004, 3'd1, 32'hFF);                    // R5 priority FF
        offer(24'h000123, 8'h40);
        chk("R12 irq high", {31'b0, irq_o}, 32'h1);
        poll(rv); chk("R3 poll", rv, 32'hFF000123);
        poll(rv); chk("R3 poll repeat", rv, 32'hFF000123);
        acc(1'b1, 1'b0, 12'h000, 3'd1, 32'h0, rv, ev);
        chk("R3 byte peek", rv, 32'h000000FF);

        // R10: worse and tied offers dropped, better replaces
        offer(24'h000055, 8'h50);
        poll(rv); chk("R10 worse dropped", rv, 32'hFF000123);
        offer(24'h000066, 8'h40);
        poll(rv); chk("R10 tie keeps", rv, 32'hFF000123);
        offer(24'h000000, 8'h01);
        poll(rv); chk("R10 source 0 ignored", rv, 32'hFF000123);
        offer(24'h000077, 8'h30);
        poll(rv); chk("R10 better replaces", rv, 32'hFF000077);

        // R4: accept
        acc(1'b1, 1'b0, 12'h004, 3'd4, 32'h0, rv, ev);
        chk("R4 accept data", rv, 32'hFF000077);
        chk("R4 irq low", {31'b0, irq_o}, 32'h0);
        poll(rv); chk("R4 after accept", rv, 32'h30000000);
        acc(1'b1, 1'b0, 12'h004, 3'd1, 32'h0, rv, ev);
        chk("R3 byte peek at 4", rv, 32'h00000030);
        acc(1'b1, 1'b0, 12'h004, 3'd4, 32'h0, rv, ev);
        chk("R4 empty accept", rv, 32'h30000000);
        poll(rv); chk("R4 empty no change", rv, 32'h30000000);

        // R10: offer not better than priority
        offer(24'h000088, 8'h30);
        offer(24'h000089, 8'h31);
        poll(rv); chk("R10 vs priority", rv, 32'h30000000);
        chk("R12 irq stays low", {31'b0, irq_o}, 32'h0);

        // R6: end of interrupt
        wr_op(12'h004, 3'd4, 32'hFF000077);
        poll(rv); chk("R6 eoi priority", rv, 32'hFF000000);

        // R5: priority write discards
        offer(24'h000099, 8'h20);
        wr_op(12'h004, 3'd1, 32'h20);
        poll(rv); chk("R5 discard", rv, 32'h20000000);
        chk("R5 irq low", {31'b0, irq_o}, 32'h0);
        wr_op(12'h004, 3'd1, 32'hFF);
        offer(24'h00009A, 8'h20);
        wr_op(12'h004, 3'd1, 32'h21);
        poll(rv); chk("R5 keep", rv, 32'h2100009A);
        chk("R12 irq high kept", {31'b0, irq_o}, 32'h1);
        wr_op(12'h004, 3'd4, 32'h10000000);
        poll(rv); chk("R6 discard", rv, 32'h10000000);

        // R11: inter-processor request
        wr_op(12'h004, 3'd4, 32'hFF000000);
        wr_op(12'h00C, 3'd1, 32'h05);
        poll(rv); chk("R11 ipi", rv, 32'hFF000002);
        chk("R12 ipi irq", {31'b0, irq_o}, 32'h1);
        acc(1'b1, 1'b0, 12'h00C, 3'd1, 32'h0, rv, ev);
        chk("R7 req read", rv, 32'h00000005);
        offer(24'h000123, 8'h04);
        poll(rv); chk("R10 beats ipi", rv, 32'hFF000123);
        acc(1'b1, 1'b0, 12'h004, 3'd4, 32'h0, rv, ev);
        chk("R4 accept ext", rv, 32'hFF000123);
        poll(rv); chk("R11 ipi held off", rv, 32'h04000000);
        wr_op(12'h004, 3'd4, 32'hFF000000);
        poll(rv); chk("R11 ipi again", rv, 32'hFF000002);
        acc(1'b1, 1'b0, 12'h004, 3'd4, 32'h0, rv, ev);
        poll(rv); chk("R4 accept ipi", rv, 32'h05000000);
        wr_op(12'h00C, 3'd1, 32'hFF);
        wr_op(12'h004, 3'd4, 32'hFF000000);
        poll(rv); chk("R11 cleared", rv, 32'hFF000000);
        offer(24'h000044, 8'h20);
        wr_op(12'h00C, 3'd1, 32'h20);
        poll(rv); chk("R11 tie keeps ext", rv, 32'hFF000044);
        wr_op(12'h00C, 3'd1, 32'h1F);
        poll(rv); chk("R11 preempts", rv, 32'hFF000002);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1 irq reset", {31'b0, irq_o}, 32'h0);
        poll(rv); chk("R1 poll reset", rv, 32'h00000000);
        acc(1'b1, 1'b0, 12'h00C, 3'd1, 32'h0, rv, ev);
        chk("R1 req reset", rv, 32'h000000FF);
        acc(1'b1, 1'b0, 12'h010, 3'd4, 32'h0, rv, ev);
        chk("R1 link reset", rv, 32'h00000000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule